// File: doc/BRIEF.md
# Trigger-Stepped Circular Parameter Table

This block keeps a table of parameter words, for example oscillator tuning words for frequency hopping or a set of filter coefficients, and hands one entry to a downstream consumer on each ranging trigger. The entries are handed over in circular order. A programmable length sets where the sequence wraps back to the start. The trigger arrives asynchronously. The block synchronises it and acts only on its rising edge. It then fetches the next entry and presents it together with a one-cycle load strobe and a level that reports a settled output. All of this completes within a few clock cycles, far inside the microsecond-scale deadline that the system allows.

A host fills the table and sets the active length through a simple address/data/write-enable port. It must do so while the block is disabled. Enabling the block rewinds the sequence, so the first trigger after enable delivers entry 0. A bypass input forces the output to a fixed word and makes the block deaf to triggers. When bypass is released, the sequence continues where it stopped. Words wider than one entry are handled by placing several copies side by side.

Top module: `trig_param_stepper`

## Requirements
- R1: After reset, paramOut, loadStrobe, loadDone and wrRejected are all 0, and the active length equals the table depth (128 by default).
- R2: While enabled and not bypassed, each rising edge of trigIn loads the next table entry in circular order. The first trigger after enable rises always loads entry 0.
- R3: The active length L (1 to depth) sets the wrap point. After entry L-1 the next trigger loads entry 0.
- R4: Take the first rising clock edge that samples trigIn high. On the fourth rising edge after it, counting that edge as the first, paramOut carries the new entry and loadStrobe is 1 for exactly one cycle.
- R5: loadDone falls one cycle before the strobe edge and rises together with loadStrobe. Once a load completes, it stays high until the next accepted trigger.
- R6: While bypass is 1, paramOut equals bypassValue and triggers produce no strobe and do not advance the sequence. After bypass is released, the next trigger loads the entry that would have come next.
- R7: While enable is 0, triggers produce no strobe and paramOut holds its last loaded value.
- R8: A table write or length write made while enable is 1 is discarded. wrRejected is 1 for the one cycle after the write cycle.
- R9: A length write with value 0 or greater than the depth is discarded and flagged on wrRejected in the same way, even while disabled.
- R10: A trigger held high for many cycles loads exactly one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; its rising edge rewinds the sequence |
| bypass | input | 1 | Force output to bypassValue and ignore triggers |
| bypassValue | input | WIDTH | Word shown while bypassed |
| trigIn | input | 1 | Asynchronous ranging trigger |
| hostWrEn | input | 1 | Table write enable |
| hostAddr | input | ADDR_W | Table write address |
| hostData | input | WIDTH | Table write data |
| lenWrEn | input | 1 | Active length write enable |
| lenValue | input | LEN_W | Active length, 1 to depth |
| paramOut | output | WIDTH | Word presented to the consumer |
| loadStrobe | output | 1 | One-cycle pulse with each new word |
| loadDone | output | 1 | Output word is settled |
| wrRejected | output | 1 | Pulse after a discarded host write |

## Verification
A pointer that skips, repeats or wraps at the wrong length shows up at the consumer's very next load strobe as the wrong table word. The bench predicts every word from its own model of the table and the length, so such an error is seen within one trigger. A trigger that is lost or counted twice shifts every later word. A broken enable rewind shows on the first load after re-enable. A write that leaks through while enabled appears when the sequence reaches the touched entry or the wrap point. A broken latency pipeline shows as a strobe or done edge in the wrong cycle, counted from the trigger.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef struct packed {
    logic memWr;
    logic lenWr;
    logic ptrClear;
    logic readAdv;
    logic present;
  } tpsCtl_t;
endpackage

// File: rtl/tps_ctrl.sv
module tps_ctrl
  import tps_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(DEPTH),
  parameter int LEN_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              bypass,
  input  logic              trigIn,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              lenWrEn,
  input  logic [LEN_W-1:0]  lenValue,
  output tpsCtl_t           ctl,
  output logic              loadStrobe,
  output logic              loadDone,
  output logic              wrRejected
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(DEPTH);

  logic [SYNC_STAGES-1:0] syncQ;
  logic trigPrev;
  logic enPrev;
  logic presentQ;
  logic trigRise;
  logic addrOk;
  logic lenOk;
  logic rejectNext;

  // metastability chain, one flop per stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ[0] <= trigIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign trigRise = syncQ[SYNC_STAGES-1] & ~trigPrev;
  assign addrOk   = LEN_W'(hostAddr) < MAX_LEN;
  assign lenOk    = (lenValue != '0) && (lenValue <= MAX_LEN);

  always_comb begin
    ctl.memWr    = hostWrEn & ~enable & addrOk;
    ctl.lenWr    = lenWrEn & ~enable & lenOk;
    ctl.ptrClear = enable & ~enPrev;
    // a trigger in the enable-rise cycle is dropped so the rewind wins
    ctl.readAdv  = trigRise & enable & enPrev & ~bypass;
    ctl.present  = presentQ;
    rejectNext   = (hostWrEn & (enable | ~addrOk)) | (lenWrEn & (enable | ~lenOk));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigPrev   <= 1'b0;
      enPrev     <= 1'b0;
      presentQ   <= 1'b0;
      loadStrobe <= 1'b0;
      loadDone   <= 1'b0;
      wrRejected <= 1'b0;
    end else begin
      trigPrev   <= syncQ[SYNC_STAGES-1];
      enPrev     <= enable;
      presentQ   <= ctl.readAdv;
      loadStrobe <= presentQ;
      wrRejected <= rejectNext;
      if (ctl.readAdv)   loadDone <= 1'b0;
      else if (presentQ) loadDone <= 1'b1;
    end
  end
endmodule

// File: rtl/tps_datapath.sv
module tps_datapath
  import tps_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int DEPTH  = 128,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tpsCtl_t           ctl,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WIDTH-1:0]  hostData,
  input  logic [LEN_W-1:0]  lenValue,
  output logic [WIDTH-1:0]  paramVal
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(DEPTH);

  logic [WIDTH-1:0]  tableMem [DEPTH];
  logic [WIDTH-1:0]  rdData;
  logic [LEN_W-1:0]  lenReg;
  logic [ADDR_W-1:0] rdPtr;
  logic              atWrap;

  assign atWrap = (LEN_W'(rdPtr) == lenReg - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (ctl.memWr) tableMem[hostAddr] <= hostData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg   <= MAX_LEN;
      rdPtr    <= '0;
      rdData   <= '0;
      paramVal <= '0;
    end else begin
      if (ctl.lenWr) lenReg <= lenValue;
      if (ctl.ptrClear) begin
        rdPtr <= '0;
      end else if (ctl.readAdv) begin
        rdPtr <= atWrap ? '0 : rdPtr + ADDR_W'(1);
      end
      if (ctl.readAdv) rdData   <= tableMem[rdPtr];
      if (ctl.present) paramVal <= rdData;
    end
  end
endmodule

// File: rtl/trig_param_stepper.sv
module trig_param_stepper
  import tps_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int DEPTH       = 128,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(DEPTH),
  parameter int LEN_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              bypass,
  input  logic [WIDTH-1:0]  bypassValue,
  input  logic              trigIn,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WIDTH-1:0]  hostData,
  input  logic              lenWrEn,
  input  logic [LEN_W-1:0]  lenValue,
  output logic [WIDTH-1:0]  paramOut,
  output logic              loadStrobe,
  output logic              loadDone,
  output logic              wrRejected
);
  tpsCtl_t          ctl;
  logic [WIDTH-1:0] paramVal;

  tps_ctrl #(
    .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .bypass(bypass), .trigIn(trigIn),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .lenWrEn(lenWrEn), .lenValue(lenValue),
    .ctl(ctl), .loadStrobe(loadStrobe), .loadDone(loadDone), .wrRejected(wrRejected)
  );

  tps_datapath #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hostAddr(hostAddr), .hostData(hostData),
    .lenValue(lenValue), .paramVal(paramVal)
  );

  assign paramOut = bypass ? bypassValue : paramVal;
endmodule

// File: rtl/tps_checker.sv
module tps_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic bypass,
  input logic hostWrEn,
  input logic lenWrEn,
  input logic loadStrobe,
  input logic loadDone,
  input logic wrRejected
);
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> !loadStrobe);

  assert_done_with_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> loadDone);

  assert_done_fall_then_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(loadDone) |=> loadStrobe);

  assert_bypass_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> !$past(bypass, 2));

  assert_disabled_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> $past(enable, 2));

  assert_table_reject_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && enable) |=> wrRejected);

  assert_len_reject_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lenWrEn && enable) |=> wrRejected);
endmodule

bind trig_param_stepper tps_checker uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .bypass(bypass),
  .hostWrEn(hostWrEn), .lenWrEn(lenWrEn),
  .loadStrobe(loadStrobe), .loadDone(loadDone), .wrRejected(wrRejected)
);

// File: tb/sim_trig_param_stepper.sv
module sim_trig_param_stepper;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic        clk = 1'b0;
  logic        rstN, enable, bypass, trigIn, hostWrEn, lenWrEn;
  logic [31:0] bypassValue, hostData;
  logic [6:0]  hostAddr;
  logic [7:0]  lenValue;
  logic [31:0] paramOut;
  logic        loadStrobe, loadDone, wrRejected;

  int nChecks = 0;
  int nFail = 0;
  logic [31:0] model [DEPTH];
  int expLen, expPtr;
  logic [31:0] lastOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_param_stepper u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .bypass(bypass), .bypassValue(bypassValue),
    .trigIn(trigIn), .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostData(hostData),
    .lenWrEn(lenWrEn), .lenValue(lenValue), .paramOut(paramOut),
    .loadStrobe(loadStrobe), .loadDone(loadDone), .wrRejected(wrRejected)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int nextPtr(input int p, input int len);
    return (p + 1 == len) ? 0 : p + 1;
  endfunction

  task automatic fire(input string tag);
    trigIn = 1'b1;
    tick(); tick();
    trigIn = 1'b0;
    check(loadStrobe == 1'b0, {tag, " R4 early strobe"}, 32'(loadStrobe), 0);
    tick();
    check(loadDone == 1'b0, {tag, " R5 done low"}, 32'(loadDone), 0);
    tick();
    check(loadStrobe == 1'b1, {tag, " R4 strobe"}, 32'(loadStrobe), 1);
    check(loadDone == 1'b1, {tag, " R5 done high"}, 32'(loadDone), 1);
    check(paramOut == model[expPtr], {tag, " value"}, paramOut, model[expPtr]);
    lastOut = model[expPtr];
    expPtr = nextPtr(expPtr, expLen);
    tick();
    check(loadStrobe == 1'b0, {tag, " R4 one cycle"}, 32'(loadStrobe), 0);
    tick(); tick();
  endtask

  task automatic fireIgnored(input string tag);
    bit seen = 1'b0;
    trigIn = 1'b1;
    tick(); tick();
    trigIn = 1'b0;
    for (int k = 0; k < 6; k++) begin
      tick();
      if (loadStrobe) seen = 1'b1;
    end
    check(!seen, {tag, " no strobe"}, 32'(seen), 0);
    check(paramOut == (bypass ? bypassValue : lastOut), {tag, " output held"},
          paramOut, bypass ? bypassValue : lastOut);
  endtask

  task automatic hostWrite(input int addr, input logic [31:0] data, output bit rej);
    hostAddr = 7'(addr); hostData = data; hostWrEn = 1'b1;
    tick();
    rej = wrRejected;
    hostWrEn = 1'b0;
    tick();
  endtask

  task automatic lenWrite(input int v, output bit rej);
    lenValue = 8'(v); lenWrEn = 1'b1;
    tick();
    rej = wrRejected;
    lenWrEn = 1'b0;
    tick();
  endtask

  task automatic setEnable(input bit b);
    enable = b;
    tick(); tick();
    if (b) expPtr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    bit rej;
    int cnt;
    void'($urandom(32'd20240611));
    rstN = 1'b0; enable = 1'b0; bypass = 1'b0; trigIn = 1'b0;
    hostWrEn = 1'b0; lenWrEn = 1'b0; hostAddr = '0; hostData = '0;
    lenValue = '0; bypassValue = '0; lastOut = '0;
    expLen = DEPTH; expPtr = 0;
    repeat (3) tick();
    // R1 reset state
    check(paramOut == 0, "R1 paramOut", paramOut, 0);
    check(loadStrobe == 0, "R1 loadStrobe", 32'(loadStrobe), 0);
    check(loadDone == 0, "R1 loadDone", 32'(loadDone), 0);
    check(wrRejected == 0, "R1 wrRejected", 32'(wrRejected), 0);
    rstN = 1'b1;
    tick();

    for (int i = 0; i < DEPTH; i++) begin
      model[i] = $urandom;
      hostWrite(i, model[i], rej);
      if (i < 4) check(rej == 0, "R8 write accepted while disabled", 32'(rej), 0);
    end

    // R1/R3: default length is full depth, wrap after 128
    setEnable(1'b1);
    for (int i = 0; i < DEPTH + 3; i++) fire("R1 R2 R3 default length");

    // R9: bad lengths rejected, R3 short length
    setEnable(1'b0);
    lenWrite(5, rej);   check(rej == 0, "R3 len accepted", 32'(rej), 0);
    lenWrite(0, rej);   check(rej == 1, "R9 len zero", 32'(rej), 1);
    lenWrite(200, rej); check(rej == 1, "R9 len too big", 32'(rej), 1);
    check(wrRejected == 0, "R8 reject pulse one cycle", 32'(wrRejected), 0);
    expLen = 5;
    setEnable(1'b1);
    for (int i = 0; i < 12; i++) fire("R2 R3 length five");

    // R8: writes while enabled are discarded
    hostWrite(0, ~model[0], rej); check(rej == 1, "R8 table write while enabled", 32'(rej), 1);
    lenWrite(3, rej);             check(rej == 1, "R8 len write while enabled", 32'(rej), 1);
    for (int i = 0; i < 8; i++) fire("R8 contents and length unchanged");

    // R7: disabled ignores triggers; re-enable rewinds
    setEnable(1'b0);
    fireIgnored("R7 disabled");
    setEnable(1'b1);
    fire("R2 first after enable is entry 0");

    // R6: bypass
    bypass = 1'b1; bypassValue = $urandom;
    tick();
    check(paramOut == bypassValue, "R6 bypass value", paramOut, bypassValue);
    fireIgnored("R6 bypass");
    bypass = 1'b0;
    tick();
    check(paramOut == lastOut, "R6 release restores", paramOut, lastOut);
    fire("R6 sequence resumes");

    // R10: long trigger loads once
    cnt = 0;
    trigIn = 1'b1;
    for (int k = 0; k < 14; k++) begin tick(); if (loadStrobe) cnt++; end
    trigIn = 1'b0;
    for (int k = 0; k < 4; k++) begin tick(); if (loadStrobe) cnt++; end
    check(cnt == 1, "R10 strobe count", 32'(cnt), 1);
    check(paramOut == model[expPtr], "R10 value", paramOut, model[expPtr]);
    lastOut = model[expPtr];
    expPtr = nextPtr(expPtr, expLen);

    // random mix
    for (int it = 0; it < 250; it++) begin
      int r = int'($urandom % 12);
      if (r == 0) begin
        setEnable(1'b0);
        expLen = 1 + int'($urandom % DEPTH);
        lenWrite(expLen, rej);
        check(rej == 0, "R3 random len accepted", 32'(rej), 0);
        for (int j = 0; j < 3; j++) begin
          int a = int'($urandom % DEPTH);
          model[a] = $urandom;
          hostWrite(a, model[a], rej);
        end
        setEnable(1'b1);
      end else if (r == 1) begin
        bypass = 1'b1; bypassValue = $urandom;
        tick();
        fireIgnored("R6 random bypass");
        bypass = 1'b0;
        tick();
      end else begin
        fire("R2 R3 random");
      end
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule